// File: doc/BRIEF.md
# Link Initialisation Handshake Register Block

This block is the register file that sits between a host and an embedded initialisation engine. It coordinates a one-time start-up of the serial links. The host writes a single word to the init register. That word carries a start request and a 2-bit forward-error-correction (FEC) choice for each of eight links. The block accepts the request only while neither START nor DONE is set. When it accepts, it latches the FEC choices and gives the engine a one-cycle start pulse.

When the engine finishes, it pulses a done strobe together with two 16-bit retimer status words. The block then sets DONE and captures both words in the same cycle. The host polls DONE, reads the status words, and decides from the group codes and mode IDs whether FEC applies. The block also works out that decision itself and drives it on an output. A read-only firmware version word, set by a parameter, tells the host whether the start handshake is available at all. The handshake exists when the major number is 3 or more. The engine also sets DONE on its own when no start was ever requested.

Top module: `init_handshake_ctrl`

## Requirements
- R1: After reset the init register, both retimer status registers, the start pulse, the latched FEC output and the read data are all zero.
- R2: A host write to address 0x1000 with bit 1 (START) set, while START and DONE are both clear, has three effects. It drives `start_pulse` high for exactly one cycle, starting the cycle after the write. It sets START. It latches bits [23:8] onto `fec_req`. Link k (A0..A3 = 0..3, B0..B3 = 4..7) owns bits [2k+9:2k+8]. The codes are 0 none, 1 KR, 2 RS.
- R3: A START write while START or DONE is already set produces no pulse and leaves the latched FEC fields unchanged.
- R4: A write to the init register with bit 1 clear has no effect. Writes to bit 0 (DONE) never change it.
- R5: A done strobe sets DONE (bit 0 of the init register). In the same clock edge it captures the two engine status words into retimer A (0x1020) and retimer B (0x1024). DONE then stays set until reset.
- R6: Address 0x1004 returns the version parameter: patch in [23:20], minor in [27:24], major in [31:28]. Bus writes do not alter it.
- R7: Read data is registered. A read issued in one cycle presents its word after the next edge and holds it until the next read. Unmapped addresses read zero. The init word shows DONE at bit 0, START at bit 1 and the FEC fields at [23:8].
- R8: `fec_capable` is high when at least one retimer status has group code [15:8] equal to 0 (OK) and a mode ID [7:0] that FEC applies to. Those IDs are 2 (4x25G), 3 (2x25G), 4 (2x25G+2x10G) and 5 (1x25G). IDs 0 (reset) and 1 (4x10G) do not qualify.
- R9: Bus writes to the retimer status addresses do not change them.
- R10: A done strobe sets DONE even when a status word reports a non-zero group code. Such a retimer never qualifies for FEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 16 | Host register address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered read data |
| start_pulse | output | 1 | One-cycle start request to the engine |
| fec_req | output | 16 | Latched per-link FEC requests |
| eng_done | input | 1 | Engine completion strobe |
| eng_stat_a | input | 16 | Retimer A status word from the engine |
| eng_stat_b | input | 16 | Retimer B status word from the engine |
| fec_capable | output | 1 | At least one retimer runs a mode that FEC applies to |

## Verification
Every result here is due exactly one edge after its stimulus. The start pulse, the START bit, the latched FEC fields, DONE and the captured status words all update on the edge that samples the write or the strobe. `fec_capable` follows combinationally from the captured words. Read data appears on the edge that samples `bus_rd`. The bench keeps a behavioural model that advances on the same edge and compares outputs a quarter period later. Its directed reads are sampled on the falling edge after the read edge. The directed start-pulse checks are sampled on the falling edge after the write edge.

// File: rtl/hs_ctrl_pkg.sv
package hs_ctrl_pkg;
  localparam int HS_ADDR_W   = 16;
  localparam logic [HS_ADDR_W-1:0] ADR_INIT    = 16'h1000;
  localparam logic [HS_ADDR_W-1:0] ADR_VERSION = 16'h1004;
  localparam logic [HS_ADDR_W-1:0] ADR_STAT_A  = 16'h1020;
  localparam logic [HS_ADDR_W-1:0] ADR_STAT_B  = 16'h1024;

  localparam int BIT_DONE  = 0;
  localparam int BIT_START = 1;
  localparam int FEC_LSB   = 8;

  typedef enum logic [1:0] {
    FEC_NONE = 2'd0,
    FEC_KR   = 2'd1,
    FEC_RS   = 2'd2
  } fec_code_e;

  typedef enum logic [7:0] {
    MODE_RESET   = 8'd0,
    MODE_4X10G   = 8'd1,
    MODE_4X25G   = 8'd2,
    MODE_2X25G   = 8'd3,
    MODE_MIXED   = 8'd4,
    MODE_1X25G   = 8'd5
  } mode_id_e;
endpackage

// File: rtl/hs_init_reg.sv
module hs_init_reg #(
  parameter int FEC_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_init,
  input  logic                wr_start_bit,
  input  logic [FEC_BITS-1:0] wr_fec,
  input  logic                eng_done,
  output logic                start_q,
  output logic                done_q,
  output logic [FEC_BITS-1:0] fec_q,
  output logic                pulse_q
);
  logic                accept;
  logic                start_d;
  logic                done_d;
  logic [FEC_BITS-1:0] fec_d;

  always_comb begin
    accept  = wr_init && wr_start_bit && !start_q && !done_q;
    start_d = start_q | accept;
    done_d  = done_q | eng_done;
    fec_d   = fec_q;
    if (accept) begin
      fec_d = wr_fec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      fec_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      pulse_q <= accept;
      if (accept) begin
        fec_q <= fec_d;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R2
  AST_PULSE_SETS_START: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> start_q); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q || done_q) |=> !pulse_q); // R3
  AST_FEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> $stable(fec_q)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R5
endmodule

// File: rtl/hs_mode_status.sv
module hs_mode_status #(
  parameter int NUM_RT = 2,
  parameter int STAT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eng_done,
  input  logic [NUM_RT*STAT_W-1:0] eng_stat,
  output logic [NUM_RT*STAT_W-1:0] stat_q,
  output logic                     fec_capable
);
  localparam int HALF_W = STAT_W / 2;

  logic [NUM_RT-1:0] rt_ok;

  for (genvar r = 0; r < NUM_RT; r++) begin : g_rt
    logic [STAT_W-1:0] word_d;
    logic [HALF_W-1:0] grp;
    logic [HALF_W-1:0] mid;

    always_comb begin
      word_d = stat_q[r*STAT_W +: STAT_W];
      if (eng_done) begin
        word_d = eng_stat[r*STAT_W +: STAT_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[r*STAT_W +: STAT_W] <= '0;
      end else if (eng_done) begin
        stat_q[r*STAT_W +: STAT_W] <= word_d;
      end
    end

    assign grp = stat_q[r*STAT_W + HALF_W +: HALF_W];
    assign mid = stat_q[r*STAT_W +: HALF_W];
    assign rt_ok[r] = (grp == '0) && (mid != HALF_W'(0)) && (mid != HALF_W'(1));

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (stat_q[r*STAT_W +: STAT_W] == $past(eng_stat[r*STAT_W +: STAT_W]))); // R5
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_done |=> $stable(stat_q[r*STAT_W +: STAT_W])); // R9
  end

  assign fec_capable = |rt_ok;
endmodule

// File: rtl/hs_read_mux.sv
module hs_read_mux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter logic [DATA_W-1:0] FW_VERSION = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     init_word,
  input  logic [2*STAT_W-1:0]   stat_flat,
  output logic [DATA_W-1:0]     rdata
);
  import hs_ctrl_pkg::*;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (addr == ADDR_W'(ADR_INIT)) begin
      rdata_d = init_word;
    end else if (addr == ADDR_W'(ADR_VERSION)) begin
      rdata_d = FW_VERSION;
    end else if (addr == ADDR_W'(ADR_STAT_A)) begin
      rdata_d = DATA_W'(stat_flat[0 +: STAT_W]);
    end else if (addr == ADDR_W'(ADR_STAT_B)) begin
      rdata_d = DATA_W'(stat_flat[STAT_W +: STAT_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rdata_d;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R7
endmodule

// File: rtl/init_handshake_ctrl.sv
module init_handshake_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int N_LINKS  = 8,
  parameter int FEC_W    = 2,
  parameter int STAT_W   = 16,
  parameter logic [31:0] FW_VERSION = 32'h3120_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       start_pulse,
  output logic [N_LINKS*FEC_W-1:0]   fec_req,
  input  logic                       eng_done,
  input  logic [STAT_W-1:0]          eng_stat_a,
  input  logic [STAT_W-1:0]          eng_stat_b,
  output logic                       fec_capable
);
  import hs_ctrl_pkg::*;

  localparam int FEC_BITS = N_LINKS * FEC_W;
  localparam int NUM_RT   = 2;

  logic                  wr_init;
  logic                  start_q;
  logic                  done_q;
  logic [FEC_BITS-1:0]   fec_q;
  logic [DATA_W-1:0]     init_word;
  logic [NUM_RT*STAT_W-1:0] stat_flat;
  logic                  unused_wdata;

  assign wr_init = bus_wr && (bus_addr == ADDR_W'(ADR_INIT));
  assign unused_wdata = ^{bus_wdata[DATA_W-1:FEC_LSB+FEC_BITS],
                          bus_wdata[FEC_LSB-1:BIT_START+1], bus_wdata[BIT_DONE]};

  hs_init_reg #(.FEC_BITS(FEC_BITS)) u_init (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_init      (wr_init),
    .wr_start_bit (bus_wdata[BIT_START]),
    .wr_fec       (bus_wdata[FEC_LSB +: FEC_BITS]),
    .eng_done     (eng_done),
    .start_q      (start_q),
    .done_q       (done_q),
    .fec_q        (fec_q),
    .pulse_q      (start_pulse)
  );

  always_comb begin
    init_word = '0;
    init_word[BIT_DONE]  = done_q;
    init_word[BIT_START] = start_q;
    init_word[FEC_LSB +: FEC_BITS] = fec_q;
  end

  hs_mode_status #(.NUM_RT(NUM_RT), .STAT_W(STAT_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_done    (eng_done),
    .eng_stat    ({eng_stat_b, eng_stat_a}),
    .stat_q      (stat_flat),
    .fec_capable (fec_capable)
  );

  hs_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .FW_VERSION(DATA_W'(FW_VERSION))
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .init_word (init_word),
    .stat_flat (stat_flat),
    .rdata     (bus_rdata)
  );

  assign fec_req = fec_q;

  AST_DONE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_q); // R5
  AST_FEC_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |-> $stable(fec_req)); // R4
endmodule

// File: tb/test_init_handshake_ctrl.sv
module test_init_handshake_ctrl;
  localparam int CLK_P = 10;
  localparam logic [31:0] VER = 32'h3120_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        start_pulse;
  logic [15:0] fec_req;
  logic        eng_done = 1'b0;
  logic [15:0] eng_stat_a = '0;
  logic [15:0] eng_stat_b = '0;
  logic        fec_capable;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  init_handshake_ctrl #(.FW_VERSION(VER)) i_init_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_pulse(start_pulse), .fec_req(fec_req), .eng_done(eng_done),
    .eng_stat_a(eng_stat_a), .eng_stat_b(eng_stat_b), .fec_capable(fec_capable)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  bit          m_start, m_done, m_pulse;
  logic [15:0] m_fec, m_sa, m_sb;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [15:0] a);
    case (a)
      16'h1000: return {8'h00, m_fec, 6'b0, m_start, m_done};
      16'h1004: return VER;
      16'h1020: return {16'h0, m_sa};
      16'h1024: return {16'h0, m_sb};
      default:  return 32'h0;
    endcase
  endfunction

  function automatic bit m_cap(input logic [15:0] s);
    int id;
    id = int'(s[7:0]);
    return (s[15:8] == 8'h00) && (id != 0) && (id != 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_done = 0; m_pulse = 0;
      m_fec = '0; m_sa = '0; m_sb = '0; m_rdata = '0;
    end else begin
      bit acc;
      if (bus_rd) m_rdata = m_read(bus_addr);
      acc = bus_wr && bus_addr == 16'h1000 && bus_wdata[1] && !m_start && !m_done;
      m_pulse = acc;
      if (acc) begin
        m_start = 1;
        m_fec = bus_wdata[23:8];
      end
      if (eng_done) begin
        m_done = 1;
        m_sa = eng_stat_a;
        m_sb = eng_stat_b;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !finished) begin
      chk("R2 start_pulse", {31'b0, start_pulse}, {31'b0, m_pulse});
      chk("R2 fec_req", {16'b0, fec_req}, {16'b0, m_fec});
      chk("R7 bus_rdata", bus_rdata, m_rdata);
      chk("R8 fec_capable", {31'b0, fec_capable}, {31'b0, m_cap(m_sa) || m_cap(m_sb)});
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic done_strobe(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); eng_done = 1; eng_stat_a = a; eng_stat_b = b;
    @(negedge clk); eng_done = 0; eng_stat_a = '0; eng_stat_b = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 start_pulse", {31'b0, start_pulse}, 32'h0);
    chk("R1 fec_req", {16'b0, fec_req}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd_chk(16'h1000, 32'h0, "R1 init");
    rd_chk(16'h1020, 32'h0, "R1 stat A");
    rd_chk(16'h1024, 32'h0, "R1 stat B");
    // R6 version, read-only
    rd_chk(16'h1004, VER, "R6 version");
    wr(16'h1004, 32'hFFFF_FFFF);
    rd_chk(16'h1004, VER, "R6 version after write");
    // R7 unmapped
    rd_chk(16'h1008, 32'h0, "R7 unmapped");
    // R4 write without START bit
    wr(16'h1000, 32'h00AA_AA01);
    rd_chk(16'h1000, 32'h0, "R4 no start");
    // R2 accepted start with RS on every link
    wr(16'h1000, 32'h00AA_AA02);
    chk("R2 pulse high", {31'b0, start_pulse}, 32'h1);
    @(negedge clk);
    chk("R2 pulse one cycle", {31'b0, start_pulse}, 32'h0);
    chk("R2 fec latched", {16'b0, fec_req}, 32'h0000_AAAA);
    rd_chk(16'h1000, 32'h00AA_AA02, "R2 init word");
    // R3 second start with KR ignored
    wr(16'h1000, 32'h0055_5502);
    chk("R3 no pulse", {31'b0, start_pulse}, 32'h0);
    rd_chk(16'h1000, 32'h00AA_AA02, "R3 fields kept");
    // R5 engine done, A=4x25G B=4x10G
    done_strobe(16'h0002, 16'h0001);
    rd_chk(16'h1000, 32'h00AA_AA03, "R5 done bit");
    rd_chk(16'h1020, 32'h0000_0002, "R5 stat A");
    rd_chk(16'h1024, 32'h0000_0001, "R5 stat B");
    chk("R8 capable via A", {31'b0, fec_capable}, 32'h1);
    // R9 status not writable
    wr(16'h1020, 32'h0000_FFFF);
    wr(16'h1024, 32'h0000_FFFF);
    rd_chk(16'h1020, 32'h0000_0002, "R9 stat A kept");
    rd_chk(16'h1024, 32'h0000_0001, "R9 stat B kept");
    // R8 both 10G or reset: not capable
    done_strobe(16'h0001, 16'h0000);
    chk("R8 not capable", {31'b0, fec_capable}, 32'h0);
    done_strobe(16'h0000, 16'h0005);
    chk("R8 capable via B", {31'b0, fec_capable}, 32'h1);

    // legacy path: done without start, failed group
    do_reset();
    chk("R1 after reset", {31'b0, fec_capable}, 32'h0);
    done_strobe(16'h0303, 16'h0104);
    rd_chk(16'h1000, 32'h0000_0001, "R10 done despite error");
    chk("R10 failed group not capable", {31'b0, fec_capable}, 32'h0);
    // R3 start after DONE ignored
    wr(16'h1000, 32'h0055_5502);
    chk("R3 no pulse after done", {31'b0, start_pulse}, 32'h0);
    rd_chk(16'h1000, 32'h0000_0001, "R3 init after done");
    // R4 DONE bit cannot be cleared
    wr(16'h1000, 32'h0000_0000);
    rd_chk(16'h1000, 32'h0000_0001, "R4 done kept");

    // R2 mixed per-link codes
    do_reset();
    wr(16'h1000, 32'h0024_9202);
    chk("R2 mixed pulse", {31'b0, start_pulse}, 32'h1);
    rd_chk(16'h1000, 32'h0024_9202, "R2 mixed fields");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule